// File: doc/BRIEF.md
# Shuffler Configuration Search Controller

This block hunts for a wiring of a chained PUF network whose response stream looks random. The network consists of nodes joined by shufflers. Each shuffler routes every output bit of one node to an input bit of the next node, following a permutation vector. A start pulse opens a search.

The controller draws a fresh set of permutations for all shufflers. It uses a Fisher–Yates shuffle fed by a 32-bit LFSR and performs one swap per clock. It then writes the vectors into the network and issues a stream of challenges through a valid/response handshake. Each returned response bit is scored on the fly. A monobit count of ones is kept, together with a count of transitions between consecutive bits.

When the sample is complete, both counts are compared against programmable inclusive windows. A candidate that passes ends the search, and its configuration is held on an output. A candidate that fails causes the next one to be drawn, until the attempt budget is spent. The user then reads the done and found flags, the attempt count and the winning configuration.

Top module: `ssc_search_top`

## Requirements
- R1: After reset, done, found, the attempt count, the winning configuration, the challenge valid and the configuration write strobe are all zero.
- R2: Each attempt writes every shuffler exactly once, in select order 0 up to NUM_SHUF-1, with one write strobe per vector. In vector field k (IDX_W bits at bit k*IDX_W) the number of the previous node's output that feeds input k is stored, and the fields of one vector form a permutation of 0..NODE_W-1.
- R3: Challenge valid and the challenge value stay unchanged until a clock edge on which the response valid input is high. A response counts only on such an edge, and each attempt consumes exactly SAMPLE_BITS responses.
- R4: The frequency check passes when the number of ones in the sample lies within [ones_lo, ones_hi], bounds included.
- R5: The runs check passes when the number of positions where a sample bit differs from the bit before it lies within [trans_lo, trans_hi], bounds included. An attempt passes only when both R4 and R5 pass.
- R6: At the first passing attempt the search stops with done and found high and the attempt count equal to the 1-based number of that attempt. The winning configuration then equals the vectors written in that attempt, with shuffler s at bits [s*VEC_W +: VEC_W].
- R7: After MAX_TRIES failing attempts, done is high, found is low and the attempt count equals MAX_TRIES. No further writes or challenges follow.
- R8: A start pulse during a running search has no effect on its course or outcome.
- R9: A start pulse while idle clears done, found and the count on the next edge. The winning configuration changes only when a search succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Search start pulse |
| ones_lo_i | input | CNT_W | Lower bound of ones count |
| ones_hi_i | input | CNT_W | Upper bound of ones count |
| trans_lo_i | input | CNT_W | Lower bound of transition count |
| trans_hi_i | input | CNT_W | Upper bound of transition count |
| cfg_wr_o | output | 1 | Shuffler vector write strobe |
| cfg_sel_o | output | SEL_W | Shuffler being written |
| cfg_vec_o | output | VEC_W | Permutation vector |
| chal_valid_o | output | 1 | Challenge valid |
| chal_o | output | NODE_W | Challenge to the network |
| resp_valid_i | input | 1 | Response valid, completes a handshake |
| resp_i | input | 1 | Response bit |
| done_o | output | 1 | Search finished |
| found_o | output | 1 | A passing configuration was found |
| tries_o | output | TRY_W | Attempts evaluated |
| win_cfg_o | output | CFG_W | Winning configuration |

## Verification
The situations hardest to reach from the ports are a pass on a late attempt and a start pulse arriving mid-search, because the candidate permutations are pseudo-random. The bench counts attempts itself from the select-0 write strobes. It returns a response pattern chosen by attempt number, so it can make exactly one chosen attempt pass and predict the count and winning vectors. It stretches the handshake with irregular response delays and pulses start once the second attempt has begun.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHUF,
        ST_WRITE,
        ST_SAMPLE,
        ST_JUDGE
    } ssc_state_e;
endpackage

// File: rtl/ssc_lfsr.sv
module ssc_lfsr #(
    parameter logic [31:0] SEED  = 32'h1ACE_B00C,
    parameter int          OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [OUT_W-1:0] rnd_o
);
    localparam logic [31:0] TAPS = 32'hA300_0000;

    logic [31:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv_i) begin
            state_d = (state_q >> 1) ^ (state_q[0] ? TAPS : 32'd0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign rnd_o = state_q[OUT_W-1:0];

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) state_q != 32'd0); // R2
endmodule

// File: rtl/ssc_perm_gen.sv
module ssc_perm_gen #(
    parameter  int NODE_W   = 8,
    parameter  int NUM_SHUF = 2,
    localparam int IDX_W    = $clog2(NODE_W),
    localparam int SH_W     = (NUM_SHUF > 1) ? $clog2(NUM_SHUF) : 1,
    localparam int CFG_W    = NUM_SHUF * NODE_W * IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             step_i,
    input  logic [15:0]      rnd_i,
    output logic             fin_o,
    output logic [CFG_W-1:0] cfg_o
);
    typedef logic [NUM_SHUF-1:0][NODE_W-1:0][IDX_W-1:0] perm_t;

    typedef struct packed {
        perm_t            perm;
        logic [SH_W-1:0]  sh;
        logic [IDX_W-1:0] pos;
        logic             fin;
    } pg_t;

    function automatic perm_t ident();
        perm_t p;
        for (int s = 0; s < NUM_SHUF; s++) begin
            for (int k = 0; k < NODE_W; k++) begin
                p[s][k] = IDX_W'(k);
            end
        end
        return p;
    endfunction

    pg_t              d, q;
    logic [IDX_W-1:0] j;
    logic [IDX_W-1:0] a_val, b_val;

    always_comb begin
        d     = q;
        j     = IDX_W'(rnd_i % (16'(q.pos) + 16'd1));
        a_val = q.perm[q.sh][q.pos];
        b_val = q.perm[q.sh][j];
        if (init_i) begin
            d.perm = ident();
            d.sh   = '0;
            d.pos  = IDX_W'(NODE_W - 1);
            d.fin  = 1'b0;
        end else if (step_i && !q.fin) begin
            d.perm[q.sh][q.pos] = b_val;
            d.perm[q.sh][j]     = a_val;
            if (q.pos == IDX_W'(1)) begin
                if (q.sh == SH_W'(NUM_SHUF - 1)) begin
                    d.fin = 1'b1;
                end else begin
                    d.sh  = q.sh + SH_W'(1);
                    d.pos = IDX_W'(NODE_W - 1);
                end
            end else begin
                d.pos = q.pos - IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{perm: ident(), sh: '0, pos: '0, fin: 1'b1};
        else        q <= d;
    end

    assign fin_o = q.fin;
    assign cfg_o = q.perm;

    logic [NUM_SHUF-1:0][NODE_W-1:0] seen;
    always_comb begin
        seen = '0;
        for (int s = 0; s < NUM_SHUF; s++) begin
            for (int k = 0; k < NODE_W; k++) begin
                seen[s][q.perm[s][k]] = 1'b1;
            end
        end
    end

    AST_PERM_VALID: assert property (@(posedge clk) disable iff (!rst_n) &seen); // R2
endmodule

// File: rtl/ssc_scorer.sv
module ssc_scorer #(
    parameter  int SAMPLE_BITS = 10000,
    localparam int CNT_W       = $clog2(SAMPLE_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic             bit_i,
    input  logic [CNT_W-1:0] ones_lo_i,
    input  logic [CNT_W-1:0] ones_hi_i,
    input  logic [CNT_W-1:0] trans_lo_i,
    input  logic [CNT_W-1:0] trans_hi_i,
    output logic             last_o,
    output logic             pass_o
);
    typedef struct packed {
        logic [CNT_W-1:0] ones;
        logic [CNT_W-1:0] trans;
        logic [CNT_W-1:0] nbits;
        logic             prev;
    } sc_t;

    sc_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d = '0;
        end else if (vld_i) begin
            d.nbits = q.nbits + CNT_W'(1);
            d.ones  = q.ones + CNT_W'(bit_i);
            if (q.nbits != '0 && bit_i != q.prev) begin
                d.trans = q.trans + CNT_W'(1);
            end
            d.prev = bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign last_o = (q.nbits == CNT_W'(SAMPLE_BITS - 1));
    assign pass_o = (q.ones >= ones_lo_i) && (q.ones <= ones_hi_i) &&
                    (q.trans >= trans_lo_i) && (q.trans <= trans_hi_i);

    AST_ONES_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n) q.ones <= q.nbits); // R4
    AST_TRANS_LT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        q.nbits != '0 |-> q.trans < q.nbits); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && !clr_i |-> q.nbits < CNT_W'(SAMPLE_BITS)); // R3
endmodule

// File: rtl/ssc_search_top.sv
module ssc_search_top #(
    parameter  int          NODE_W      = 8,
    parameter  int          NUM_SHUF    = 2,
    parameter  int          SAMPLE_BITS = 10000,
    parameter  int          MAX_TRIES   = 100,
    parameter  logic [31:0] SEED        = 32'h1ACE_B00C,
    localparam int          IDX_W       = $clog2(NODE_W),
    localparam int          VEC_W       = NODE_W * IDX_W,
    localparam int          CFG_W       = NUM_SHUF * VEC_W,
    localparam int          CNT_W       = $clog2(SAMPLE_BITS + 1),
    localparam int          TRY_W       = $clog2(MAX_TRIES + 1),
    localparam int          SEL_W       = (NUM_SHUF > 1) ? $clog2(NUM_SHUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] ones_lo_i,
    input  logic [CNT_W-1:0] ones_hi_i,
    input  logic [CNT_W-1:0] trans_lo_i,
    input  logic [CNT_W-1:0] trans_hi_i,
    output logic             cfg_wr_o,
    output logic [SEL_W-1:0] cfg_sel_o,
    output logic [VEC_W-1:0] cfg_vec_o,
    output logic             chal_valid_o,
    output logic [NODE_W-1:0] chal_o,
    input  logic             resp_valid_i,
    input  logic             resp_i,
    output logic             done_o,
    output logic             found_o,
    output logic [TRY_W-1:0] tries_o,
    output logic [CFG_W-1:0] win_cfg_o
);
    import ssc_pkg::*;

    typedef struct packed {
        ssc_state_e        state;
        logic [SEL_W-1:0]  wr_idx;
        logic [TRY_W-1:0]  tries;
        logic              done;
        logic              found;
        logic [CFG_W-1:0]  win;
        logic              chal_vld;
        logic [NODE_W-1:0] chal;
        logic              cfg_wr;
        logic [SEL_W-1:0]  cfg_sel;
        logic [VEC_W-1:0]  cfg_vec;
    } top_t;

    top_t d, q;

    logic                             pg_init, pg_step, pg_fin;
    logic [NUM_SHUF-1:0][VEC_W-1:0]   pg_cfg;
    logic                             sc_clr, sc_vld, sc_last, sc_pass;
    logic [15:0]                      rnd;
    logic                             accept;

    ssc_lfsr #(.SEED(SEED), .OUT_W(16)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (q.state != ST_IDLE),
        .rnd_o (rnd)
    );

    ssc_perm_gen #(.NODE_W(NODE_W), .NUM_SHUF(NUM_SHUF)) u_perm (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (pg_init),
        .step_i (pg_step),
        .rnd_i  (rnd),
        .fin_o  (pg_fin),
        .cfg_o  (pg_cfg)
    );

    ssc_scorer #(.SAMPLE_BITS(SAMPLE_BITS)) u_score (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sc_clr),
        .vld_i      (sc_vld),
        .bit_i      (resp_i),
        .ones_lo_i  (ones_lo_i),
        .ones_hi_i  (ones_hi_i),
        .trans_lo_i (trans_lo_i),
        .trans_hi_i (trans_hi_i),
        .last_o     (sc_last),
        .pass_o     (sc_pass)
    );

    assign accept = q.chal_vld && resp_valid_i;

    always_comb begin
        d        = q;
        d.cfg_wr = 1'b0;
        pg_init  = 1'b0;
        pg_step  = 1'b0;
        sc_clr   = 1'b0;
        sc_vld   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.done  = 1'b0;
                    d.found = 1'b0;
                    d.tries = '0;
                    pg_init = 1'b1;
                    d.state = ST_SHUF;
                end
            end
            ST_SHUF: begin
                if (pg_fin) begin
                    d.wr_idx = '0;
                    d.state  = ST_WRITE;
                end else begin
                    pg_step = 1'b1;
                end
            end
            ST_WRITE: begin
                d.cfg_wr  = 1'b1;
                d.cfg_sel = q.wr_idx;
                d.cfg_vec = pg_cfg[q.wr_idx];
                sc_clr    = 1'b1;
                if (q.wr_idx == SEL_W'(NUM_SHUF - 1)) begin
                    d.chal_vld = 1'b1;
                    d.chal     = rnd[NODE_W-1:0];
                    d.state    = ST_SAMPLE;
                end else begin
                    d.wr_idx = q.wr_idx + SEL_W'(1);
                end
            end
            ST_SAMPLE: begin
                if (accept) begin
                    sc_vld = 1'b1;
                    if (sc_last) begin
                        d.chal_vld = 1'b0;
                        d.state    = ST_JUDGE;
                    end else begin
                        d.chal = rnd[NODE_W-1:0];
                    end
                end
            end
            ST_JUDGE: begin
                d.tries = q.tries + TRY_W'(1);
                if (sc_pass) begin
                    d.done  = 1'b1;
                    d.found = 1'b1;
                    d.win   = pg_cfg;
                    d.state = ST_IDLE;
                end else if (q.tries == TRY_W'(MAX_TRIES - 1)) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    pg_init = 1'b1;
                    d.state = ST_SHUF;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_wr_o     = q.cfg_wr;
    assign cfg_sel_o    = q.cfg_sel;
    assign cfg_vec_o    = q.cfg_vec;
    assign chal_valid_o = q.chal_vld;
    assign chal_o       = q.chal;
    assign done_o       = q.done;
    assign found_o      = q.found;
    assign tries_o      = q.tries;
    assign win_cfg_o    = q.win;

    AST_FOUND_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) q.found |-> q.done); // R6
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n) q.tries <= TRY_W'(MAX_TRIES)); // R7
    AST_CHAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        q.chal_vld && !resp_valid_i |=> q.chal_vld && $stable(q.chal)); // R3
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == ST_SAMPLE && start_i |=> $stable(q.tries) && !q.done); // R8
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        q.state != ST_JUDGE |=> $stable(q.win)); // R9
endmodule

// File: tb/ssc_search_top_tb.sv
module ssc_search_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int NS = 2;
    localparam int SB = 16;
    localparam int MT = 4;
    localparam int IW = 2;
    localparam int VW = NW * IW;
    localparam int CW = NS * VW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [4:0] ones_lo, ones_hi, tr_lo, tr_hi;
    logic cfg_wr_o;
    logic [0:0] cfg_sel_o;
    logic [VW-1:0] cfg_vec_o;
    logic chal_valid_o;
    logic [NW-1:0] chal_o;
    logic resp_valid_i = 1'b0;
    logic resp_i = 1'b0;
    logic done_o, found_o;
    logic [2:0] tries_o;
    logic [CW-1:0] win_cfg_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ssc_search_top #(.NODE_W(NW), .NUM_SHUF(NS), .SAMPLE_BITS(SB), .MAX_TRIES(MT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ones_lo_i(ones_lo), .ones_hi_i(ones_hi), .trans_lo_i(tr_lo), .trans_hi_i(tr_hi),
        .cfg_wr_o(cfg_wr_o), .cfg_sel_o(cfg_sel_o), .cfg_vec_o(cfg_vec_o),
        .chal_valid_o(chal_valid_o), .chal_o(chal_o),
        .resp_valid_i(resp_valid_i), .resp_i(resp_i),
        .done_o(done_o), .found_o(found_o), .tries_o(tries_o), .win_cfg_o(win_cfg_o)
    );

    int checks = 0, errors = 0;
    int att = 0, bidx = 0, nresp = 0, cyc = 0;
    int exp_sel = 0, perm_bad = 0, sel_bad = 0, hold_bad = 0;
    int good_pat = 0, bad_pat = 0, pass_att = 0, nfirst = 0;
    logic [CW-1:0] cur_cfg = '0;
    logic [CW-1:0] cfg_hist [0:MT+1];
    logic [CW-1:0] prev_win = '0;
    bit prev_wait = 1'b0;
    logic [NW-1:0] prev_chal = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic bit pat_bit(input int p, input int i);
        case (p)
            0: return 1'b1;
            1: return (i % 2) == 0;
            2: return i < nfirst;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit pat_passes(input int p, input int olo, input int ohi,
                                      input int tlo, input int thi);
        int ones = 0;
        int trans = 0;
        for (int i = 0; i < SB; i++) begin
            ones += int'(pat_bit(p, i));
            if (i > 0 && pat_bit(p, i) != pat_bit(p, i - 1)) trans++;
        end
        return ones >= olo && ones <= ohi && trans >= tlo && trans <= thi;
    endfunction

    // network model: configuration monitor and response driver
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                resp_valid_i = 1'b0;
            end else begin
                if (cfg_wr_o) begin
                    logic [NW-1:0] seen;
                    if (cfg_sel_o == 1'b0) begin
                        att++;
                        bidx = 0;
                    end
                    if (int'(cfg_sel_o) != exp_sel) sel_bad++;
                    exp_sel = (int'(cfg_sel_o) + 1) % NS;
                    seen = '0;
                    for (int k = 0; k < NW; k++) seen[cfg_vec_o[k*IW +: IW]] = 1'b1;
                    if (seen != '1) perm_bad++;
                    cur_cfg[int'(cfg_sel_o)*VW +: VW] = cfg_vec_o;
                    if (int'(cfg_sel_o) == NS - 1 && att <= MT + 1) cfg_hist[att] = cur_cfg;
                end
                if (prev_wait && (!chal_valid_o || chal_o != prev_chal)) hold_bad++;
                if (chal_valid_o && (cyc % 3 != 2)) begin
                    resp_valid_i = 1'b1;
                    resp_i = pat_bit((att == pass_att) ? good_pat : bad_pat, bidx);
                    bidx++;
                    nresp++;
                    prev_wait = 1'b0;
                end else begin
                    resp_valid_i = 1'b0;
                    prev_wait = chal_valid_o;
                end
                prev_chal = chal_o;
            end
        end
    end

    task automatic run(input int olo, input int ohi, input int tlo, input int thi,
                       input int gp, input int bp, input int pa, input int nf,
                       input bit busy_start, input string tag);
        int exp_tries = MT;
        bit exp_found = 1'b0;
        int wait_n;
        int att_end;
        good_pat = gp; bad_pat = bp; pass_att = pa; nfirst = nf;
        for (int a = 1; a <= MT; a++) begin
            if (!exp_found && pat_passes((a == pa) ? gp : bp, olo, ohi, tlo, thi)) begin
                exp_found = 1'b1;
                exp_tries = a;
            end
        end
        ones_lo = 5'(olo); ones_hi = 5'(ohi); tr_lo = 5'(tlo); tr_hi = 5'(thi);
        att = 0; nresp = 0; exp_sel = 0; perm_bad = 0; sel_bad = 0; hold_bad = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(done_o == 1'b0 && found_o == 1'b0 && tries_o == 3'd0, {"R9 clear ", tag}, done_o, 0);
        if (busy_start) begin
            wait_n = 0;
            while (att < 2 && wait_n < 2000) begin @(negedge clk); wait_n++; end
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        wait_n = 0;
        while (!done_o && wait_n < 5000) begin @(negedge clk); wait_n++; end
        chk(done_o == 1'b1, {"R7 done ", tag}, done_o, 1);
        chk(found_o == exp_found, {"R6 found ", tag}, found_o, exp_found);
        chk(int'(tries_o) == exp_tries, {"R7 tries ", tag}, tries_o, exp_tries);
        chk(nresp == exp_tries * SB, {"R3 responses ", tag}, nresp, exp_tries * SB);
        chk(hold_bad == 0, {"R3 hold ", tag}, hold_bad, 0);
        chk(perm_bad == 0 && sel_bad == 0, {"R2 vectors ", tag}, perm_bad + sel_bad, 0);
        chk(att == exp_tries, {"R8 attempts ", tag}, att, exp_tries);
        if (exp_found) begin
            chk(win_cfg_o == cfg_hist[exp_tries], {"R6 win ", tag}, win_cfg_o, cfg_hist[exp_tries]);
            prev_win = cfg_hist[exp_tries];
        end else begin
            chk(win_cfg_o == prev_win, {"R9 win held ", tag}, win_cfg_o, prev_win);
        end
        att_end = att;
        repeat (20) @(negedge clk);
        chk(att == att_end && !chal_valid_o && done_o, {"R7 quiet ", tag}, att, att_end);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done_o == 0 && found_o == 0 && tries_o == 0, "R1 status", tries_o, 0);
        chk(win_cfg_o == '0 && !chal_valid_o && !cfg_wr_o, "R1 outputs", win_cfg_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R7: all-ones sample never fits [6,10]
        run(6, 10, 0, 15, 0, 0, 0, 0, 1'b0, "budget");
        // R5 R6: alternating sample passes only on attempt 3
        run(6, 10, 10, 15, 1, 3, 3, 0, 1'b0, "late pass");
        // R4 boundaries: six ones, one transition
        run(6, 6, 0, 15, 2, 2, 0, 6, 1'b0, "ones lo edge");
        run(7, 12, 0, 15, 2, 2, 0, 6, 1'b0, "ones below");
        run(0, 5, 0, 15, 2, 2, 0, 6, 1'b0, "ones above");
        run(0, 6, 0, 15, 2, 2, 0, 6, 1'b0, "ones hi edge");
        // R5 boundaries: alternating has 15 transitions
        run(0, 16, 15, 15, 1, 1, 0, 0, 1'b0, "trans edge");
        run(0, 16, 0, 14, 1, 1, 0, 0, 1'b0, "trans above");
        // R8: start pulse in the middle of a run
        run(6, 10, 0, 15, 0, 0, 0, 0, 1'b1, "busy start");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule